// File: doc/BRIEF.md
# MATS+ March Test Sequencer

This block is a built-in self-test sequencer for a synchronous single-port RAM. When it is started, it runs the three-element MATS+ march over every address of the memory under test. It drives the address, write-enable, read-enable and write-data lines of that memory, checks each word it reads back, and keeps a flag and the address of the first word that read back wrong.

The march has three elements. First it fills the whole memory with zeros, working upward from address 0. Next it climbs from the lowest address to the highest. At each address it reads the word, expects all zeros, and then writes all ones. Last it descends from the highest address to the lowest. At each address it reads the word, expects all ones, and then writes all zeros. Reads have one cycle of latency, so every read-then-write pair takes two cycles. A full run therefore lasts five cycles per address, and it leaves the memory cleared.

A one-cycle `done` pulse marks the end of a run. After that pulse, `fail` and `fail_addr` stay valid until the next accepted start. The sequencer always finishes the full march, even after it finds a fault.

Top module: `mats_plus_bist`

## Requirements
- R1: After an accepted start, the first element writes the all-zeros word once to every address, in ascending order from 0 to 2^AW-1, one write per cycle.
- R2: The second element visits addresses in ascending order. At each address it issues a read in one cycle, and in the next cycle it writes the all-ones word to the same address.
- R3: The third element visits addresses in descending order from 2^AW-1 to 0. At each address it issues a read in one cycle, and in the next cycle it writes the all-zeros word to the same address.
- R4: Read-enable and write-enable are never high together. `busy` stays high for exactly 5·2^AW cycles after a start is accepted. `done` is high for exactly one cycle, which is the first cycle after `busy` falls.
- R5: On a fault-free memory, every location holds the all-zeros word after a run.
- R6: Each read is checked on all DW bits in the cycle after it is issued. The expected value is all zeros in the second element and all ones in the third. The first mismatch sets `fail` and captures its address in `fail_addr`. Later mismatches change neither output, and the march still completes.
- R7: `start` is ignored while `busy` is high.
- R8: A start accepted while idle clears `fail` and `fail_addr` to 0 in the first busy cycle.
- R9: Reset is synchronous and active low. It returns the sequencer to idle with `busy`, `done`, `fail`, `mem_we` and `mem_re` all low, even in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run; sampled only while idle |
| busy | output | 1 | March in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| fail | output | 1 | A mismatch was seen during the last run |
| fail_addr | output | AW | Address of the first mismatch |
| mem_addr | output | AW | Address to the memory under test |
| mem_we | output | 1 | Write enable to the memory |
| mem_re | output | 1 | Read enable to the memory |
| mem_wdata | output | DW | Write data to the memory |
| mem_rdata | input | DW | Read data, valid one cycle after mem_re |

## Verification
The assertions assume that the memory returns read data exactly one cycle after `mem_re`. They also assume that reset is held for at least one clock edge before the first run. Beyond that, they constrain only the sequencer's own outputs.

The bench memory model honours this one-cycle latency. Its faults are only stuck-at bits applied on the read path, so the timing stays within that assumption while the data can still disagree with the expected value. The bench drives `start` during a run, and it drops reset in the middle of a march, only at points away from the active clock edge.

// File: rtl/mats_pkg.sv
package mats_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL_WR,
        ST_UP_RD,
        ST_UP_WR,
        ST_DN_RD,
        ST_DN_WR
    } march_state_e;

    typedef enum logic [2:0] {
        AG_HOLD,
        AG_CLR,
        AG_INC,
        AG_DEC
    } addr_op_e;

endpackage

// File: rtl/mats_addr_gen.sv
module mats_addr_gen #(
    parameter int AW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  mats_pkg::addr_op_e op,
    output logic [AW-1:0]      addr,
    output logic               at_top,
    output logic               at_bottom
);
    localparam logic [AW-1:0] TOP_ADDR = '1;

    logic [AW-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        case (op)
            mats_pkg::AG_CLR: addr_d = '0;
            mats_pkg::AG_INC: addr_d = addr_q + 1'b1;
            mats_pkg::AG_DEC: addr_d = addr_q - 1'b1;
            default:          addr_d = addr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr      = addr_q;
    assign at_top    = (addr_q == TOP_ADDR);
    assign at_bottom = (addr_q == '0);
endmodule

// File: rtl/mats_cmp.sv
module mats_cmp #(
    parameter int DW = 8
) (
    input  logic          en,
    input  logic          exp_ones,
    input  logic [DW-1:0] rdata,
    output logic          mismatch
);
    logic [DW-1:0] bit_diff;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign bit_diff[i] = rdata[i] ^ exp_ones;
    end

    assign mismatch = en & (|bit_diff);
endmodule

// File: rtl/mats_fail_log.sv
module mats_fail_log #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          hit,
    input  logic [AW-1:0] hit_addr,
    output logic          fail,
    output logic [AW-1:0] fail_addr
);
    typedef struct packed {
        logic          flag;
        logic [AW-1:0] addr;
    } log_t;

    log_t log_d, log_q;

    always_comb begin
        log_d = log_q;
        if (clr) begin
            log_d.flag = 1'b0;
            log_d.addr = '0;
        end else if (hit && !log_q.flag) begin
            log_d.flag = 1'b1;
            log_d.addr = hit_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) log_q <= '0;
        else        log_q <= log_d;
    end

    assign fail      = log_q.flag;
    assign fail_addr = log_q.addr;
endmodule

// File: rtl/mats_plus_bist.sv
module mats_plus_bist #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic          mem_re,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    import mats_pkg::*;

    typedef struct packed {
        march_state_e state;
        logic         done;
    } seq_t;

    seq_t          seq_d, seq_q;
    addr_op_e      ag_op;
    logic [AW-1:0] cur_addr;
    logic          at_top, at_bottom;
    logic          log_clr;
    logic          cmp_en, cmp_ones, mismatch;

    mats_addr_gen #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (ag_op),
        .addr      (cur_addr),
        .at_top    (at_top),
        .at_bottom (at_bottom)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        ag_op      = AG_HOLD;
        log_clr    = 1'b0;
        case (seq_q.state)
            ST_IDLE: begin
                if (start) begin
                    seq_d.state = ST_FILL_WR;
                    ag_op       = AG_CLR;
                    log_clr     = 1'b1;
                end
            end
            ST_FILL_WR: begin
                if (at_top) begin
                    seq_d.state = ST_UP_RD;
                    ag_op       = AG_CLR;
                end else begin
                    ag_op = AG_INC;
                end
            end
            ST_UP_RD: seq_d.state = ST_UP_WR;
            ST_UP_WR: begin
                if (at_top) begin
                    seq_d.state = ST_DN_RD;
                end else begin
                    seq_d.state = ST_UP_RD;
                    ag_op       = AG_INC;
                end
            end
            ST_DN_RD: seq_d.state = ST_DN_WR;
            ST_DN_WR: begin
                if (at_bottom) begin
                    seq_d.state = ST_IDLE;
                    seq_d.done  = 1'b1;
                end else begin
                    seq_d.state = ST_DN_RD;
                    ag_op       = AG_DEC;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.state <= ST_IDLE;
            seq_q.done  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cmp_en   = (seq_q.state == ST_UP_WR) || (seq_q.state == ST_DN_WR);
    assign cmp_ones = (seq_q.state == ST_DN_WR);

    mats_cmp #(.DW(DW)) u_cmp (
        .en       (cmp_en),
        .exp_ones (cmp_ones),
        .rdata    (mem_rdata),
        .mismatch (mismatch)
    );

    mats_fail_log #(.AW(AW)) u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (log_clr),
        .hit       (mismatch),
        .hit_addr  (cur_addr),
        .fail      (fail),
        .fail_addr (fail_addr)
    );

    assign busy      = (seq_q.state != ST_IDLE);
    assign done      = seq_q.done;
    assign mem_addr  = cur_addr;
    assign mem_re    = (seq_q.state == ST_UP_RD) || (seq_q.state == ST_DN_RD);
    assign mem_we    = (seq_q.state == ST_FILL_WR) || (seq_q.state == ST_UP_WR)
                    || (seq_q.state == ST_DN_WR);
    assign mem_wdata = (seq_q.state == ST_UP_WR) ? {DW{1'b1}} : {DW{1'b0}};
endmodule

// File: rtl/mats_plus_bist_chk.sv
module mats_plus_bist_chk #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          fail,
    input logic [AW-1:0] fail_addr,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic          mem_re,
    input logic [DW-1:0] mem_wdata
);
    assert_no_rw_clash_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));

    // R2 and R3: each read is followed by a write to the same address
    assert_read_then_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (mem_we && mem_addr == $past(mem_addr)));

    assert_word_solid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == '0 || mem_wdata == '1));

    assert_first_fail_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && busy) |=> (fail && $stable(fail_addr)));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re));
endmodule

bind mats_plus_bist mats_plus_bist_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .fail_addr (fail_addr),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_wdata (mem_wdata)
);

// File: tb/mats_plus_bist_bench.sv
`timescale 1ns/1ps
module mats_plus_bist_bench;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, fail;
    logic [AW-1:0] fail_addr, mem_addr;
    logic          mem_we, mem_re;
    logic [DW-1:0] mem_wdata, mem_rdata;

    always #2 clk = ~clk;

    mats_plus_bist #(.AW(AW), .DW(DW)) u_mats_plus_bist (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .fail(fail), .fail_addr(fail_addr), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // memory under test with stuck-at bits on the read path
    logic [DW-1:0] mem [N];
    logic [DW-1:0] sa0 [N];
    logic [DW-1:0] sa1 [N];
    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= (mem[mem_addr] | sa1[mem_addr]) & ~sa0[mem_addr];
    end

    typedef struct {
        logic          we;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } op_t;
    op_t exp_q[$];

    int n_checks = 0;
    int n_fail = 0;
    logic mon_en = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // monitor: compare each memory operation against the scoreboard
    always @(negedge clk) begin
        if (mon_en && (mem_we || mem_re)) begin
            if (exp_q.size() == 0) begin
                check(0, "R4", "unexpected memory op at addr", longint'(mem_addr), 0);
            end else begin
                op_t e;
                e = exp_q.pop_front();
                check(mem_we == e.we && mem_re == !e.we, "R4", "op kind (1=write)",
                      longint'(mem_we), longint'(e.we));
                check(mem_addr == e.a, e.we ? "R1/R3" : "R2", "op address",
                      longint'(mem_addr), longint'(e.a));
                if (e.we)
                    check(mem_wdata == e.d, "R1", "write data",
                          longint'(mem_wdata), longint'(e.d));
            end
        end
    end

    task automatic push_march();
        op_t o;
        for (int a = 0; a < N; a++) begin
            o.we = 1'b1; o.a = AW'(a); o.d = '0; exp_q.push_back(o);
        end
        for (int a = 0; a < N; a++) begin
            o.we = 1'b0; o.a = AW'(a); o.d = '0; exp_q.push_back(o);
            o.we = 1'b1; o.a = AW'(a); o.d = '1; exp_q.push_back(o);
        end
        for (int a = N - 1; a >= 0; a--) begin
            o.we = 1'b0; o.a = AW'(a); o.d = '0; exp_q.push_back(o);
            o.we = 1'b1; o.a = AW'(a); o.d = '0; exp_q.push_back(o);
        end
    endtask

    task automatic clear_faults();
        for (int a = 0; a < N; a++) begin
            sa0[a] = '0; sa1[a] = '0; mem[a] = 8'hA5;
        end
    endtask

    task automatic run_march(input bit exp_fail, input int exp_addr, input bit poke);
        int cnt;
        push_march();
        mon_en = 1'b1;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        check(fail == 1'b0 && fail_addr == '0, "R8", "fail cleared on start",
              longint'(fail), 0);
        cnt = 0;
        while (!done && cnt < 10 * N) begin
            if (busy) cnt++;
            if (poke) start = (cnt == 20);  // R7: start while busy
            @(negedge clk);
        end
        start = 1'b0;
        check(cnt == 5 * N, "R4", "busy cycles", longint'(cnt), longint'(5 * N));
        check(done && !busy, "R4", "done after busy", longint'(done), 1);
        @(negedge clk);
        check(!done, "R4", "done single cycle", longint'(done), 0);
        check(exp_q.size() == 0, poke ? "R7" : "R4", "ops left in scoreboard",
              longint'(exp_q.size()), 0);
        check(fail == exp_fail, "R6", "fail flag", longint'(fail), longint'(exp_fail));
        if (exp_fail)
            check(fail_addr == AW'(exp_addr), "R6", "first fail address",
                  longint'(fail_addr), longint'(exp_addr));
        mon_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        clear_faults();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy && !done && !fail && !mem_we && !mem_re, "R9", "reset state",
              longint'({busy, done, fail, mem_we, mem_re}), 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // fault-free run, then memory must be all zeros (R5)
        run_march(1'b0, 0, 1'b0);
        begin
            bit allz = 1'b1;
            for (int a = 0; a < N; a++) if (mem[a] != '0) allz = 1'b0;
            check(allz, "R5", "memory cleared after run", longint'(allz), 1);
        end

        // single stuck-at-0 bit at 5: caught in descending element
        clear_faults(); sa0[5] = 8'h10;
        run_march(1'b1, 5, 1'b0);

        // stuck-at-1 at 3 (ascending) and stuck-at-0 at 9: first is 3
        clear_faults(); sa1[3] = 8'h01; sa0[9] = 8'h80;
        run_march(1'b1, 3, 1'b0);

        // two stuck-at-0 cells: descending order finds 11 before 2
        clear_faults(); sa0[2] = 8'h04; sa0[11] = 8'h40;
        run_march(1'b1, 11, 1'b0);

        // high bit only at top address
        clear_faults(); sa0[N-1] = 8'h80;
        run_march(1'b1, N - 1, 1'b0);

        // clean run after fail, with a start pulse mid-run (R7, R8)
        clear_faults();
        run_march(1'b0, 0, 1'b1);

        // reset in the middle of a march (R9)
        push_march();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        repeat (30) @(posedge clk);
        #1 rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(!busy && !done && !fail && !mem_we && !mem_re, "R9", "mid-run reset",
              longint'({busy, done, fail, mem_we, mem_re}), 0);
        exp_q.delete();
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(!busy && !mem_we && !mem_re, "R9", "stays idle after reset",
              longint'({busy, mem_we, mem_re}), 0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule